// File: doc/BRIEF.md
# Comparison Functional Tester

This block drives one stimulus word into two devices at the same moment: the device being qualified and a known-good reference device that has the same truth table. It then checks the two response words against each other bit by bit. Because the verdict comes from a live reference, no stored table of expected outputs is needed. The stimulus comes from one of two sources. The first is an up-counter that walks the whole input space once. The second is a maximal-length pseudo-random generator that visits every nonzero word once.

Each stimulus word is held for a programmable number of settle cycles, which covers the propagation delay through both devices. The responses are compared only in the final cycle of that hold. Any differing bit sets a sticky reject flag. The flag stays set until it is cleared explicitly or the block is reset, so a single bad word cannot be missed. When the pattern space is exhausted, the run stops and a done flag is raised.

Top module: `cmp_tester`

## Requirements
- R1: After reset, `stim` is 0 and `reject`, `busy` and `done` are all 0.
- R2: In counting mode (`mode`=0), `stim` takes the values 0, 1, 2 and so on up to 2^W-1, in that order. After the compare of the all-ones word, `busy` falls and `done` rises.
- R3: In random mode (`mode`=1), the first word is 1. Each next word is the current word shifted right by one; if the bit shifted out was 1, the result is XORed with the tap mask (0xB8 for W=8). After the compare of the word whose successor would be 1 again, the run ends with `done` high, so every one of the 2^W-1 nonzero words is applied exactly once.
- R4: Every stimulus word is held for settle+1 cycles, where settle is the value sampled at start. Responses are compared only in the last of those cycles, so a difference that is gone before then never raises `reject`.
- R5: The responses are XORed. If any result bit is 1, `reject` is 1 from the clock edge that ends that word's hold.
- R6: Once set, `reject` stays 1 through later matching words and later runs. It returns to 0 only through `clr_reject` or reset.
- R7: `mode` and `settle` are sampled only at the start of a run. While `busy` is high, `start`, `mode` and `settle` have no effect.
- R8: A new start clears `done` but leaves `reject` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| mode | input | 1 | 0 = counting, 1 = pseudo-random |
| settle | input | SW | Extra hold cycles per word before the compare |
| clr_reject | input | 1 | Clears the sticky reject flag |
| dut_resp | input | OW | Response of the device being qualified |
| ref_resp | input | OW | Response of the reference device |
| stim | output | W | Stimulus word sent to both devices |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run covered its whole pattern space |
| reject | output | 1 | Sticky mismatch flag |

## Verification
The bench models a device that gives a wrong response only during the first cycle after each stimulus change. With one settle cycle no reject may appear, while with zero settle cycles one must. A design that compares too early, or holds a word for the wrong length, fails one of these two cases. A single-word fault is placed in the middle of each sequence, and the bench checks that `reject` rises exactly when the next word appears and then stays set. An off-by-one in the last-word detection shows up as a missing or extra pattern, in counting mode at the all-ones word and in random mode at the wrap back to the seed. Each run is also disturbed by toggling `mode` and `settle` and by pulsing `start`; a design that resamples its inputs in the middle of a run would change the sequence or the hold length.

// File: rtl/cmp_tester.sv
module cmp_tester #(
  parameter int W  = 8,
  parameter int OW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [SW-1:0] settle,
  input  logic          clr_reject,
  input  logic [OW-1:0] dut_resp,
  input  logic [OW-1:0] ref_resp,
  output logic [W-1:0]  stim,
  output logic          busy,
  output logic          done,
  output logic          reject
);

  function automatic logic [W-1:0] tap_mask(input int width);
    logic [15:0] m;
    case (width)
      3:  m = 16'h0006;
      4:  m = 16'h000C;
      5:  m = 16'h0014;
      6:  m = 16'h0030;
      7:  m = 16'h0060;
      8:  m = 16'h00B8;
      9:  m = 16'h0110;
      10: m = 16'h0240;
      11: m = 16'h0500;
      12: m = 16'h0E08;
      13: m = 16'h1C80;
      14: m = 16'h3802;
      15: m = 16'h6000;
      default: m = 16'hD008;
    endcase
    return m[W-1:0];
  endfunction

  localparam logic [W-1:0] MASK = tap_mask(W);
  localparam logic [W-1:0] SEED = W'(1);

  logic          rand_q;
  logic [SW-1:0] hold_q;
  logic [SW-1:0] cnt;

  wire          cmp_en   = busy && (cnt == hold_q);
  wire [W-1:0]  lfsr_nx  = stim[0] ? ((stim >> 1) ^ MASK) : (stim >> 1);
  wire          last     = rand_q ? (lfsr_nx == SEED) : (&stim);
  wire          mismatch = |(dut_resp ^ ref_resp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stim   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      rand_q <= 1'b0;
      hold_q <= '0;
      cnt    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        done   <= 1'b0;
        rand_q <= mode;
        hold_q <= settle;
        cnt    <= '0;
        stim   <= mode ? SEED : '0;
      end
    end else if (cmp_en) begin
      cnt <= '0;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        stim <= rand_q ? lfsr_nx : stim + W'(1);
      end
    end else begin
      cnt <= cnt + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 reject <= 1'b0;
    else if (cmp_en && mismatch) reject <= 1'b1;
    else if (clr_reject)        reject <= 1'b0;
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rand_q) |-> (stim != '0)); // R3
  AST_STIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmp_en) |=> $stable(stim)); // R4
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reject) |-> $past(cmp_en && mismatch)); // R5
  AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !clr_reject) |=> reject); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done)); // R8

endmodule

// File: tb/sim_cmp_tester.sv
module sim_cmp_tester;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       mode = 1'b0;
  logic [3:0] settle = '0;
  logic       clr_reject = 1'b0;
  logic [7:0] dut_resp, ref_resp, stim;
  logic       busy, done, reject;

  logic       fault_en = 1'b0;
  logic [7:0] fault_pat = '0;
  logic       lag_en = 1'b0;
  logic [7:0] stim_q = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_tester u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .settle(settle),
    .clr_reject(clr_reject), .dut_resp(dut_resp), .ref_resp(ref_resp),
    .stim(stim), .busy(busy), .done(done), .reject(reject)
  );

  function automatic logic [7:0] truth(input logic [7:0] s);
    return (s * 8'd3) ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) stim_q <= stim;

  assign ref_resp = truth(stim);
  assign dut_resp = truth(stim)
                  ^ ((fault_en && stim == fault_pat) ? 8'h10 : 8'h00)
                  ^ ((lag_en && stim != stim_q) ? 8'h01 : 8'h00);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard state
  logic [8:0] expq[$];
  int         exp_hold = 1;
  logic       exp_rand = 1'b0;
  logic       sticky = 1'b0;
  logic       finished = 1'b0;
  logic       prev_busy = 1'b0;
  logic [7:0] prev_stim = '0;
  int         hold = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && (!prev_busy || stim != prev_stim)) begin
        if (prev_busy) check("R4 hold length", hold, exp_hold);
        else           check("R8 done cleared by start", done, 0);
        check("R5 R6 R8 reject so far", reject, sticky);
        if (expq.size() == 0) begin
          check(exp_rand ? "R3 extra word" : "R2 extra word", 1, 0);
        end else begin
          logic [8:0] it;
          it = expq.pop_front();
          check(exp_rand ? "R3 R7 stimulus word" : "R2 R7 stimulus word", stim, it[7:0]);
          if (it[8]) sticky = 1'b1;
        end
        hold = 1;
      end else if (busy) begin
        hold++;
      end else if (prev_busy) begin
        check("R4 hold of last word", hold, exp_hold);
        check(exp_rand ? "R3 done" : "R2 done", done, 1);
        check(exp_rand ? "R3 all words used" : "R2 all words used", expq.size(), 0);
        check("R5 R6 reject at end", reject, sticky);
        finished = 1'b1;
      end
      prev_busy = busy;
      prev_stim = stim;
    end
  end

  task automatic run(input logic md, input logic [3:0] st, input logic fe,
                     input logic [7:0] fp, input logic le);
    logic [7:0] s, prev;
    logic mis;
    fault_en  = fe;
    fault_pat = fp;
    lag_en    = le;
    expq.delete();
    prev = stim;
    s = md ? 8'h01 : 8'h00;
    forever begin
      mis = (fe && s == fp) || (le && st == 0 && s != prev);
      expq.push_back({mis, s});
      prev = s;
      if (md) begin
        s = s[0] ? ((s >> 1) ^ 8'hB8) : (s >> 1);
        if (s == 8'h01) break;
      end else begin
        if (s == 8'hFF) break;
        s = s + 8'd1;
      end
    end
    exp_hold = st + 1;
    exp_rand = md;
    sticky   = reject;
    finished = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = md; settle = st;
    @(negedge clk);
    start = 1'b0;
    // R7: disturb inputs mid-run; none may matter
    repeat (10) @(negedge clk);
    mode = ~md; settle = st + 4'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!finished) @(negedge clk);
    fault_en = 1'b0;
    lag_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stim", stim, 0);
    check("R1 reject", reject, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);

    run(1'b0, 4'd2, 1'b0, 8'h00, 1'b0);
    check("R2 clean counting run", reject, 0);

    run(1'b0, 4'd1, 1'b1, 8'h80, 1'b0);
    check("R5 fault seen", reject, 1);

    @(negedge clk);
    check("R6 reject held at idle", reject, 1);
    clr_reject = 1'b1;
    @(negedge clk);
    clr_reject = 1'b0;
    check("R6 clear", reject, 0);

    run(1'b1, 4'd3, 1'b1, 8'h37, 1'b0);
    check("R3 R5 random fault seen", reject, 1);

    run(1'b1, 4'd0, 1'b0, 8'h00, 1'b0);
    check("R8 reject kept across start", reject, 1);

    clr_reject = 1'b1;
    @(negedge clk);
    clr_reject = 1'b0;
    check("R6 clear again", reject, 0);

    run(1'b0, 4'd1, 1'b0, 8'h00, 1'b1);
    check("R4 late glitch ignored", reject, 0);

    run(1'b0, 4'd0, 1'b0, 8'h00, 1'b1);
    check("R4 R5 glitch caught without settle", reject, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule